// File: doc/BRIEF.md
# Serial Read-Only Memory Slave Controller

This block is the serial front end of a small read-only memory that answers as an SPI slave in clock mode 0. It runs on a local system clock. The block oversamples the chip-select, serial-clock and serial-data-in lines through synchronisers and finds the serial-clock edges from those samples. The first byte of each selection picks one of three transactions: a plain read, a fast read that adds one dummy byte, or an identification read. Any other first byte sends the block into a latched standby that lasts until the host deselects it.

Both read commands take a 24-bit big-endian byte address. Read data then streams out continuously and the address advances by one after every byte. The memory contents are computed from the address, so no storage is needed. The serial output has an enable pin. When that enable is low the host must treat the output as high-impedance. The enable is low in standby and whenever chip select is released.

Top module: `spiRom`

## Requirements
- R1: After reset, soOe is 0 and the block waits for an opcode as the first byte of a selection.
- R2: Opcode 0x03 is followed by three address bytes, most significant byte first. Data bytes then follow at once. The byte at address a is a[7:0] ^ a[15:8] ^ 0xA5, with a taken modulo 2^ADDR_W (ADDR_W defaults to 16).
- R3: Opcode 0x0B uses the same address phase as 0x03. One dummy byte, whose value is ignored, then comes before the first data byte.
- R4: Opcode 0x9F is followed directly by the identification bytes 0xC2, 0x20 and 0x10. With ID_REPEAT=1 (the default) that sequence then repeats. With ID_REPEAT=0 it is followed by 0x00 bytes.
- R5: Any other opcode enters standby. In standby soOe stays 0 and further serial clocks and data are ignored until csN goes high and then low again.
- R6: When csN goes high, soOe drops to 0 within 4 system clocks, even in the middle of a byte. The transaction is abandoned and the next selection starts again with an opcode.
- R7: serialIn is sampled on rising serial-clock edges and soData changes only after falling edges. All bytes move MSB first. soOe stays 0 until the falling edge that follows the last rising edge of the opcode, address or dummy phase, and that falling edge drives the first output bit.
- R8: The read address increments after each data byte and wraps from 2^ADDR_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| serialIn | input | 1 | Serial data from the host |
| soData | output | 1 | Serial data to the host |
| soOe | output | 1 | Output enable for soData; 0 means high-impedance |

## Verification
Two functions can fall in the same system-clock cycle: the clear caused by chip-select release, and a serial-clock edge that would shift a bit in or drive a bit out. The bench provokes this by releasing chip select part-way through an opcode and part-way through a data byte. It then requires the output enable to fall, and requires the next selection to decode a fresh opcode at a byte boundary. A second overlap is the last address or dummy bit completing on the same rising edge that switches the phase to output. This is judged by checking that the enable is still low just before the following falling edge and high just before the next rising edge.

// File: rtl/spiRomPkg.sv
package spiRomPkg;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_IDENT,
    PH_STANDBY
  } phase_e;

  typedef struct packed {
    logic clear;      // chip select released
    logic sampleBit;  // rising edge in an input phase
    logic addrBit;    // rising edge in the address phase
    logic driveBit;   // falling edge in an output phase
    logic idSel;      // output comes from identification bytes
  } strobe_t;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_IDENT = 8'h9F;

endpackage

// File: rtl/spiRomCtrl.sv
module spiRomCtrl
  import spiRomPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       serialIn,
  input  logic [7:0] rxByte,
  output strobe_t    strobe,
  output logic       siS
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] csSync, sclkSync, siSync;
  logic          sclkPrev;
  logic          csS, sclkS, sclkRise, sclkFall;
  phase_e        phase;
  logic [2:0]    bitCnt;
  logic [1:0]    byteCnt;
  logic          fastMode;
  logic [7:0]    fullByte;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csSync   <= '1;
          sclkSync <= '0;
          siSync   <= '0;
        end else begin
          csSync   <= {csSync[LAST-1:0], csN};
          sclkSync <= {sclkSync[LAST-1:0], sclk};
          siSync   <= {siSync[LAST-1:0], serialIn};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csSync   <= '1;
          sclkSync <= '0;
          siSync   <= '0;
        end else begin
          csSync   <= csN;
          sclkSync <= sclk;
          siSync   <= serialIn;
        end
      end
    end
  endgenerate

  assign csS   = csSync[LAST];
  assign sclkS = sclkSync[LAST];
  assign siS   = siSync[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign fullByte = {rxByte[6:0], siS};

  always_comb begin
    strobe.clear     = csS;
    strobe.sampleBit = !csS && sclkRise &&
                       (phase == PH_OPCODE || phase == PH_ADDR || phase == PH_DUMMY);
    strobe.addrBit   = !csS && sclkRise && (phase == PH_ADDR);
    strobe.driveBit  = !csS && sclkFall && (phase == PH_DATA || phase == PH_IDENT);
    strobe.idSel     = (phase == PH_IDENT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_OPCODE;
      bitCnt   <= '0;
      byteCnt  <= '0;
      fastMode <= 1'b0;
    end else if (csS) begin
      phase    <= PH_OPCODE;
      bitCnt   <= '0;
      byteCnt  <= '0;
      fastMode <= 1'b0;
    end else if (strobe.sampleBit) begin
      bitCnt <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) begin
        unique case (phase)
          PH_OPCODE: begin
            if (fullByte == OP_READ) begin
              phase    <= PH_ADDR;
              fastMode <= 1'b0;
            end else if (fullByte == OP_FAST) begin
              phase    <= PH_ADDR;
              fastMode <= 1'b1;
            end else if (fullByte == OP_IDENT) begin
              phase <= PH_IDENT;
            end else begin
              phase <= PH_STANDBY;
            end
          end
          PH_ADDR: begin
            if (byteCnt == 2'd2) begin
              byteCnt <= '0;
              phase   <= fastMode ? PH_DUMMY : PH_DATA;
            end else begin
              byteCnt <= byteCnt + 2'd1;
            end
          end
          PH_DUMMY: phase <= PH_DATA;
          default:  phase <= phase;
        endcase
      end
    end
  end

  // R5: a standby entered on a bad opcode holds while selected
  p_standby_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STANDBY && !csS) |=> (phase == PH_STANDBY));

  // R6: release of chip select restarts every counter
  p_release_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (phase == PH_OPCODE && bitCnt == 3'd0 && byteCnt == 2'd0));

  // R7: input sampling and output driving never share a cycle
  p_edge_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.sampleBit, strobe.driveBit}));

endmodule

// File: rtl/spiRomData.sv
module spiRomData
  import spiRomPkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter logic [7:0] MFR_ID    = 8'hC2,
  parameter logic [7:0] TYPE_ID   = 8'h20,
  parameter logic [7:0] CAP_ID    = 8'h10,
  parameter bit         ID_REPEAT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strobe,
  input  logic       siS,
  output logic [7:0] rxByte,
  output logic       soData,
  output logic       soOe
);

  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  logic [23:0]       addrReg;
  logic [2:0]        oBit;
  logic [1:0]        idIdx;
  logic [23:0]       romAddr;
  logic [7:0]        romByte, idByte, curByte;
  logic [1:0]        idNext;

  assign romAddr = 24'(addrReg[ADDR_W-1:0]);
  assign romByte = romAddr[7:0] ^ romAddr[15:8] ^ 8'hA5;

  always_comb begin
    unique case (idIdx)
      2'd0:    idByte = MFR_ID;
      2'd1:    idByte = TYPE_ID;
      2'd2:    idByte = CAP_ID;
      default: idByte = 8'h00;
    endcase
    if (idIdx == 2'd2)      idNext = ID_REPEAT ? 2'd0 : 2'd3;
    else if (idIdx == 2'd3) idNext = 2'd3;
    else                    idNext = idIdx + 2'd1;
  end

  assign curByte = strobe.idSel ? idByte : romByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      addrReg <= '0;
      oBit    <= '0;
      idIdx   <= '0;
      soData  <= 1'b0;
      soOe    <= 1'b0;
    end else if (strobe.clear) begin
      rxByte <= '0;
      oBit   <= '0;
      idIdx  <= '0;
      soOe   <= 1'b0;
    end else begin
      if (strobe.sampleBit) rxByte  <= {rxByte[6:0], siS};
      if (strobe.addrBit)   addrReg <= {addrReg[22:0], siS};
      if (strobe.driveBit) begin
        soData <= curByte[3'd7 - oBit];
        soOe   <= 1'b1;
        oBit   <= oBit + 3'd1;
        if (oBit == 3'd7) begin
          if (strobe.idSel) idIdx <= idNext;
          else addrReg[ADDR_W-1:0] <= addrReg[ADDR_W-1:0] + 1'b1;
        end
      end
    end
  end

  // R6: release of chip select turns the output off
  p_release_hiz_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> !soOe);

  // R7: the output bit only moves on a falling-edge strobe
  p_so_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.driveBit |=> $stable(soData));

  // R8: the last address wraps to zero after its byte
  p_addr_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.driveBit && !strobe.idSel && oBit == 3'd7 &&
     addrReg[ADDR_W-1:0] == ADDR_MAX) |=> (addrReg[ADDR_W-1:0] == '0));

  // R4: identification index stays in its four legal values and wraps per parameter
  p_id_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.driveBit && strobe.idSel && oBit == 3'd7 && idIdx == 2'd2)
      |=> (idIdx == (ID_REPEAT ? 2'd0 : 2'd3)));

endmodule

// File: rtl/spiRom.sv
module spiRom
  import spiRomPkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MFR_ID      = 8'hC2,
  parameter logic [7:0] TYPE_ID     = 8'h20,
  parameter logic [7:0] CAP_ID      = 8'h10,
  parameter bit         ID_REPEAT   = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic serialIn,
  output logic soData,
  output logic soOe
);

  strobe_t    strobe;
  logic       siS;
  logic [7:0] rxByte;

  spiRomCtrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sclk     (sclk),
    .serialIn (serialIn),
    .rxByte   (rxByte),
    .strobe   (strobe),
    .siS      (siS)
  );

  spiRomData #(
    .ADDR_W    (ADDR_W),
    .MFR_ID    (MFR_ID),
    .TYPE_ID   (TYPE_ID),
    .CAP_ID    (CAP_ID),
    .ID_REPEAT (ID_REPEAT)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .siS    (siS),
    .rxByte (rxByte),
    .soData (soData),
    .soOe   (soOe)
  );

endmodule

// File: tb/spiRom_test.sv
module spiRom_test;

  localparam int H = 6;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic serialIn = 1'b0;
  logic soData, soOe;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  spiRom uut (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sclk     (sclk),
    .serialIn (serialIn),
    .soData   (soData),
    .soOe     (soOe)
  );

  function automatic logic [7:0] romAt(input int a);
    logic [15:0] w;
    w = 16'(a);
    return w[7:0] ^ w[15:8] ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one serial bit: data set during low phase, sampled before rise and before fall
  task automatic bitXfer(input logic b, output logic soSmp, output logic oeLow,
                         output logic oeHigh);
    serialIn = b;
    repeat (H) @(negedge clk);
    soSmp = soData;
    oeLow = soOe;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    oeHigh = soOe;
    sclk = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic oeLast, output logic oeAny);
    logic s, l, h;
    oeAny = 1'b0;
    oeLast = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bitXfer(v[i], s, l, h);
      oeAny = oeAny | l | h;
      oeLast = h;
    end
  endtask

  task automatic readByte(output logic [7:0] v, output logic oeAll, output logic oeAny);
    logic l, h;
    oeAll = 1'b1;
    oeAny = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bitXfer(1'b0, v[i], l, h);
      oeAll = oeAll & l;
      oeAny = oeAny | l;
    end
  endtask

  task automatic select();
    @(negedge clk);
    csN = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic release_cs();
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendAddr(input int a, output logic oeLast);
    logic any;
    sendByte(8'((a >> 16) & 255), oeLast, any);
    sendByte(8'((a >> 8) & 255), oeLast, any);
    sendByte(8'(a & 255), oeLast, any);
  endtask

  task automatic t_reset();
    check(soOe == 1'b0, "R1 reset soOe", int'(soOe), 0);
  endtask

  task automatic t_read();
    logic oeLast, oeAny, oeAll;
    logic [7:0] v;
    select();
    sendByte(8'h03, oeLast, oeAny);
    check(oeAny == 1'b0, "R7 oe low during opcode", int'(oeAny), 0);
    sendAddr(32'h001234, oeLast);
    check(oeLast == 1'b0, "R7 oe low before first fall", int'(oeLast), 0);
    for (int i = 0; i < 4; i++) begin
      readByte(v, oeAll, oeAny);
      check(v == romAt(32'h1234 + i), "R2 read data", int'(v), int'(romAt(32'h1234 + i)));
      check(oeAll == 1'b1, "R7 oe high while driving", int'(oeAll), 1);
    end
    // abort in the middle of a data byte
    for (int i = 0; i < 3; i++) begin
      logic s, l, h;
      bitXfer(1'b0, s, l, h);
    end
    release_cs();
    check(soOe == 1'b0, "R6 release mid byte hiz", int'(soOe), 0);
  endtask

  task automatic t_fast();
    logic oeLast, oeAny, oeAll;
    logic [7:0] v;
    int a;
    select();
    sendByte(8'h0B, oeLast, oeAny);
    sendAddr(32'h00FFFE, oeLast);
    check(oeLast == 1'b0, "R3 oe low after address in fast read", int'(oeLast), 0);
    sendByte(8'h5A, oeLast, oeAny);
    check(oeAny == 1'b0, "R3 oe low over dummy byte", int'(oeAny), 0);
    for (int i = 0; i < 4; i++) begin
      a = (32'hFFFE + i) & 32'hFFFF;
      readByte(v, oeAll, oeAny);
      check(v == romAt(a), "R8 fast read with wrap", int'(v), int'(romAt(a)));
    end
    release_cs();
  endtask

  task automatic t_ident();
    logic oeLast, oeAny, oeAll;
    logic [7:0] v;
    logic [7:0] idExp[3] = '{8'hC2, 8'h20, 8'h10};
    select();
    sendByte(8'h9F, oeLast, oeAny);
    check(oeLast == 1'b0, "R7 oe low before first id fall", int'(oeLast), 0);
    for (int i = 0; i < 5; i++) begin
      readByte(v, oeAll, oeAny);
      check(v == idExp[i % 3], "R4 identification byte", int'(v), int'(idExp[i % 3]));
    end
    release_cs();
  endtask

  task automatic t_standby();
    logic oeLast, oeAny, oeAll, oeSeen;
    logic [7:0] v;
    select();
    sendByte(8'h55, oeLast, oeAny);
    oeSeen = oeAny;
    sendByte(8'h03, oeLast, oeAny);
    oeSeen = oeSeen | oeAny;
    sendAddr(32'h000000, oeLast);
    oeSeen = oeSeen | oeLast;
    readByte(v, oeAll, oeAny);
    oeSeen = oeSeen | oeAny;
    readByte(v, oeAll, oeAny);
    oeSeen = oeSeen | oeAny;
    check(oeSeen == 1'b0, "R5 standby ignores clocks, output off", int'(oeSeen), 0);
    release_cs();
    select();
    sendByte(8'h03, oeLast, oeAny);
    sendAddr(32'h000010, oeLast);
    readByte(v, oeAll, oeAny);
    check(v == romAt(32'h10), "R5 new selection leaves standby", int'(v), int'(romAt(32'h10)));
    release_cs();
  endtask

  task automatic t_abort();
    logic oeLast, oeAny, oeAll, s, l, h;
    logic [7:0] v;
    select();
    bitXfer(1'b1, s, l, h);
    bitXfer(1'b0, s, l, h);
    bitXfer(1'b0, s, l, h);
    bitXfer(1'b1, s, l, h);
    release_cs();
    check(soOe == 1'b0, "R6 aborted opcode leaves output off", int'(soOe), 0);
    select();
    sendByte(8'h03, oeLast, oeAny);
    sendAddr(32'h000005, oeLast);
    readByte(v, oeAll, oeAny);
    check(v == romAt(5), "R6 fresh opcode after abort", int'(v), int'(romAt(5)));
    release_cs();
    check(soOe == 1'b0, "R6 output off after release", int'(soOe), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_read();
    t_fast();
    t_ident();
    t_standby();
    t_abort();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule